// File: doc/BRIEF.md
# Reconfigurable Pin Function Crossbar

This block sits between an 8-pin digital port and a set of on-chip peripherals. Each pin owns a 5-bit mapping code, held in a small register that software writes and reads through a plain register port. The code picks, at once, which peripheral output drives the pin and which peripheral input listens to it. Some codes leave the pin direction to the port's direction bit. Others hand the direction to the serial peripheral that owns the function. One code forces the pin to drive. One code cuts both the driver and the input buffer so the pin can carry an analog level.

The functions are numbered 1 to 17. The peripheral-side buses are indexed by code: bit `k-1` of `fn_out_i` is the output of function k (k = 1..17), and bit `k-1` of `fn_in_o` is the input of function k (k = 1..16). Bit `k-11` of `fn_oe_i` is the drive request of serial function k (k = 11..16). Codes 4 to 10 are timer channels 0 to 6: an alternate capture input in one direction and a compare output in the other. Codes 14 and 15 are the clock and data lines of the two-wire serial bus when `i2c_mode_i` is high. All of these are level signals with no flow control. The register port is single-cycle and has no back-pressure: a write is accepted on every clock edge where `cfg_we_i` is high.

Top module: `pin_xbar`

## Requirements
- R1: A write (`cfg_we_i`=1) stores `cfg_wdata_i[4:0]` in the register of pin `cfg_addr_i` at the next clock edge, and the upper three data bits are dropped. `cfg_rdata_o` shows the register of pin `cfg_addr_i` combinationally, with bits 7:5 reading 0.
- R2: After reset, pins 0..5 hold codes 16, 15, 14, 13, 12, 11 and pins 6 and 7 hold code 0.
- R3: Codes 0 and 18..30 route to no input function and drive the pin value 0. Output-enable follows the pin's `dir_i` bit, the input buffer is enabled, and open-drain is 0.
- R4: Code 31 clears output value, output-enable, open-drain and input enable. Writing 0xFF stores code 31.
- R5: Codes 1..10 drive the pin from `fn_out_i[code-1]`, take output-enable from `dir_i`, and deliver the pin value to `fn_in_o[code-1]`. Codes 4..10 are timer channels 0..6.
- R6: Codes 11..16 take output-enable from `fn_oe_i[code-11]` and ignore `dir_i`. Outside the two-wire mode case of R7, they drive `fn_out_i[code-1]`.
- R7: With `i2c_mode_i`=1, codes 14 and 15 are open-drain. `pin_od_o`=1 and the pin value is 0. Output-enable is `fn_oe_i[code-11] & ~fn_out_i[code-1]`, so the pin only pulls low or floats.
- R8: Code 17 is output-only. Output-enable is 1 regardless of `dir_i`, the pin value is `fn_out_i[16]`, and no input function is fed.
- R9: If several pins carry the same code 1..16, the lowest-numbered pin feeds `fn_in_o`. If no pin carries that code, the input reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Mapping register write strobe |
| cfg_addr_i | input | 3 | Pin index for read and write |
| cfg_wdata_i | input | 8 | Write data; bits 4:0 kept |
| cfg_rdata_o | output | 8 | Read data of addressed pin |
| dir_i | input | 8 | Port direction bit per pin |
| pin_in_i | input | 8 | Value seen at each pin |
| pin_out_o | output | 8 | Output value per pin |
| pin_oe_o | output | 8 | Output-enable per pin |
| pin_od_o | output | 8 | Open-drain mode per pin |
| pin_ie_o | output | 8 | Input buffer enable per pin |
| fn_out_i | input | 17 | Peripheral output per function 1..17 |
| fn_oe_i | input | 6 | Peripheral drive request, functions 11..16 |
| i2c_mode_i | input | 1 | Two-wire mode of serial functions 14/15 |
| fn_in_o | output | 16 | Peripheral input per function 1..16 |

## Verification
The assertions check these rules on every cycle, for every pin: a write lands in the addressed register, analog isolation, the forced driver of code 17, the quiet output of the unused codes, and the pull-low-only rule of open-drain pins. The bench alone can show the reset defaults and the readback format. It also shows the routing of each function's input back to the peripheral side, including the lowest-pin priority and the zero seen when no pin carries a code. To do this, the bench sweeps all 32 codes on every pin under several peripheral and direction patterns.

// File: rtl/pin_xbar_pkg.sv
package pin_xbar_pkg;
  localparam int CODE_W      = 5;
  localparam int NFN_OUT     = 17;
  localparam int NFN_IN      = 16;
  localparam int SER_FIRST   = 11;
  localparam int SER_LAST    = 16;
  localparam int NSER        = SER_LAST - SER_FIRST + 1;
  localparam int CODE_SCL    = 14;
  localparam int CODE_SDA    = 15;
  localparam int CODE_FORCED = 17;
  localparam int CODE_ANALOG = 31;

  typedef enum logic [2:0] {
    CL_IDLE, CL_PORTDIR, CL_SERIAL, CL_FORCED, CL_ANALOG
  } xb_class_e;

  function automatic xb_class_e classify(input logic [CODE_W-1:0] c);
    if (c == CODE_W'(CODE_ANALOG))                 return CL_ANALOG;
    if (c == CODE_W'(CODE_FORCED))                 return CL_FORCED;
    if (c >= CODE_W'(SER_FIRST) && c <= CODE_W'(SER_LAST)) return CL_SERIAL;
    if (c >= CODE_W'(1) && c < CODE_W'(SER_FIRST)) return CL_PORTDIR;
    return CL_IDLE;
  endfunction

  function automatic logic is_two_wire(input logic [CODE_W-1:0] c);
    return (c == CODE_W'(CODE_SCL)) || (c == CODE_W'(CODE_SDA));
  endfunction

  function automatic logic [CODE_W-1:0] reset_code(input int pin);
    return (pin < 6) ? CODE_W'(16 - pin) : CODE_W'(0);
  endfunction
endpackage

// File: rtl/xb_map_regs.sv
module xb_map_regs
  import pin_xbar_pkg::*;
#(
  parameter int NPIN = 8,
  parameter int DW   = 8,
  localparam int AW  = $clog2(NPIN)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we_i,
  input  logic [AW-1:0]            addr_i,
  input  logic [DW-1:0]            wdata_i,
  output logic [DW-1:0]            rdata_o,
  output logic [NPIN*CODE_W-1:0]   map_o
);
  logic [CODE_W-1:0] regs_q [NPIN];

  for (genvar p = 0; p < NPIN; p++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             regs_q[p] <= reset_code(p);
      else if (we_i && addr_i == AW'(p))      regs_q[p] <= wdata_i[CODE_W-1:0];
    end
    assign map_o[p*CODE_W +: CODE_W] = regs_q[p];
  end

  always_comb begin
    rdata_o = '0;
    for (int p = 0; p < NPIN; p++)
      if (addr_i == AW'(p)) rdata_o[CODE_W-1:0] = regs_q[p];
  end
endmodule

// File: rtl/xb_pin_drv.sv
module xb_pin_drv
  import pin_xbar_pkg::*;
(
  input  logic [CODE_W-1:0]  code_i,
  input  logic               dir_i,
  input  logic [NFN_OUT-1:0] fn_out_i,
  input  logic [NSER-1:0]    fn_oe_i,
  input  logic               i2c_mode_i,
  output logic               out_o,
  output logic               oe_o,
  output logic               od_o,
  output logic               ie_o
);
  logic pick_val, pick_oe;

  always_comb begin
    pick_val = 1'b0;
    for (int k = 0; k < NFN_OUT; k++)
      if (code_i == CODE_W'(k + 1)) pick_val = fn_out_i[k];
    pick_oe = 1'b0;
    for (int k = 0; k < NSER; k++)
      if (code_i == CODE_W'(SER_FIRST + k)) pick_oe = fn_oe_i[k];
  end

  always_comb begin
    out_o = 1'b0;
    oe_o  = dir_i;
    od_o  = 1'b0;
    ie_o  = 1'b1;
    unique case (classify(code_i))
      CL_PORTDIR: out_o = pick_val;
      CL_SERIAL: begin
        if (i2c_mode_i && is_two_wire(code_i)) begin
          od_o = 1'b1;
          oe_o = pick_oe & ~pick_val;
        end else begin
          out_o = pick_val;
          oe_o  = pick_oe;
        end
      end
      CL_FORCED: begin
        out_o = pick_val;
        oe_o  = 1'b1;
      end
      CL_ANALOG: begin
        oe_o = 1'b0;
        ie_o = 1'b0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/xb_in_sel.sv
module xb_in_sel
  import pin_xbar_pkg::*;
#(
  parameter int NPIN = 8
) (
  input  logic [NPIN*CODE_W-1:0] map_i,
  input  logic [NPIN-1:0]        pin_in_i,
  output logic [NFN_IN-1:0]      fn_in_o
);
  for (genvar f = 0; f < NFN_IN; f++) begin : g_fn
    always_comb begin
      fn_in_o[f] = 1'b0;
      for (int p = NPIN - 1; p >= 0; p--)
        if (map_i[p*CODE_W +: CODE_W] == CODE_W'(f + 1)) fn_in_o[f] = pin_in_i[p];
    end
  end
endmodule

// File: rtl/pin_xbar.sv
module pin_xbar
  import pin_xbar_pkg::*;
#(
  parameter int NPIN   = 8,
  parameter int CFG_DW = 8,
  localparam int AW    = $clog2(NPIN)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we_i,
  input  logic [AW-1:0]      cfg_addr_i,
  input  logic [CFG_DW-1:0]  cfg_wdata_i,
  output logic [CFG_DW-1:0]  cfg_rdata_o,
  input  logic [NPIN-1:0]    dir_i,
  input  logic [NPIN-1:0]    pin_in_i,
  output logic [NPIN-1:0]    pin_out_o,
  output logic [NPIN-1:0]    pin_oe_o,
  output logic [NPIN-1:0]    pin_od_o,
  output logic [NPIN-1:0]    pin_ie_o,
  input  logic [NFN_OUT-1:0] fn_out_i,
  input  logic [NSER-1:0]    fn_oe_i,
  input  logic               i2c_mode_i,
  output logic [NFN_IN-1:0]  fn_in_o
);
  logic [NPIN*CODE_W-1:0] map_flat;

  xb_map_regs #(.NPIN(NPIN), .DW(CFG_DW)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .we_i   (cfg_we_i),
    .addr_i (cfg_addr_i),
    .wdata_i(cfg_wdata_i),
    .rdata_o(cfg_rdata_o),
    .map_o  (map_flat)
  );

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    xb_pin_drv u_drv (
      .code_i    (map_flat[p*CODE_W +: CODE_W]),
      .dir_i     (dir_i[p]),
      .fn_out_i  (fn_out_i),
      .fn_oe_i   (fn_oe_i),
      .i2c_mode_i(i2c_mode_i),
      .out_o     (pin_out_o[p]),
      .oe_o      (pin_oe_o[p]),
      .od_o      (pin_od_o[p]),
      .ie_o      (pin_ie_o[p])
    );
  end

  xb_in_sel #(.NPIN(NPIN)) u_insel (
    .map_i   (map_flat),
    .pin_in_i(pin_in_i),
    .fn_in_o (fn_in_o)
  );
endmodule

// File: rtl/pin_xbar_chk.sv
module pin_xbar_chk
  import pin_xbar_pkg::*;
#(
  parameter int NPIN   = 8,
  parameter int CFG_DW = 8,
  localparam int AW    = $clog2(NPIN)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     cfg_we_i,
  input logic [AW-1:0]            cfg_addr_i,
  input logic [CFG_DW-1:0]        cfg_wdata_i,
  input logic [NPIN*CODE_W-1:0]   map_flat,
  input logic [NPIN-1:0]          pin_out_o,
  input logic [NPIN-1:0]          pin_oe_o,
  input logic [NPIN-1:0]          pin_od_o,
  input logic [NPIN-1:0]          pin_ie_o,
  input logic [NFN_OUT-1:0]       fn_out_i
);
  for (genvar p = 0; p < NPIN; p++) begin : g_chk
    logic [CODE_W-1:0] c;
    assign c = map_flat[p*CODE_W +: CODE_W];

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we_i && cfg_addr_i == AW'(p) |=> c == $past(cfg_wdata_i[CODE_W-1:0])); // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (c == '0 || (c >= CODE_W'(18) && c <= CODE_W'(30))) |-> !pin_out_o[p] && pin_ie_o[p] && !pin_od_o[p]); // R3
    AST_ANALOG_CUT: assert property (@(posedge clk) disable iff (!rst_n)
      c == CODE_W'(CODE_ANALOG) |-> !pin_oe_o[p] && !pin_ie_o[p] && !pin_out_o[p]); // R4
    AST_OD_PULL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      pin_od_o[p] |-> !pin_out_o[p] && is_two_wire(c)); // R7
    AST_FORCED_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      c == CODE_W'(CODE_FORCED) |-> pin_oe_o[p] && pin_out_o[p] == fn_out_i[NFN_OUT-1]); // R8
  end
endmodule

bind pin_xbar pin_xbar_chk #(.NPIN(NPIN), .CFG_DW(CFG_DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_we_i   (cfg_we_i),
  .cfg_addr_i (cfg_addr_i),
  .cfg_wdata_i(cfg_wdata_i),
  .map_flat   (map_flat),
  .pin_out_o  (pin_out_o),
  .pin_oe_o   (pin_oe_o),
  .pin_od_o   (pin_od_o),
  .pin_ie_o   (pin_ie_o),
  .fn_out_i   (fn_out_i)
);

// File: tb/test_pin_xbar.sv
module test_pin_xbar;
  localparam int CLK_PERIOD = 10;
  localparam int NPIN = 8;
  localparam int WATCHDOG = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic [7:0]  dir = '0, pin_in = '0;
  logic [7:0]  pin_out, pin_oe, pin_od, pin_ie;
  logic [16:0] fn_out = '0;
  logic [5:0]  fn_oe = '0;
  logic        i2c_mode = 1'b0;
  logic [15:0] fn_in;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_xbar i_pin_xbar (
    .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata), .dir_i(dir),
    .pin_in_i(pin_in), .pin_out_o(pin_out), .pin_oe_o(pin_oe),
    .pin_od_o(pin_od), .pin_ie_o(pin_ie), .fn_out_i(fn_out),
    .fn_oe_i(fn_oe), .i2c_mode_i(i2c_mode), .fn_in_o(fn_in)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG) begin
      errors = errors + 1;
      $display("FAIL watchdog actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Expected {out, oe, od, ie} for one pin from the requirement text.
  function automatic logic [3:0] model(input int c, input logic d);
    logic o, e, od, ie;
    o = 0; e = d; od = 0; ie = 1;
    if (c == 31) begin e = 0; ie = 0; end                       // R4
    else if (c == 17) begin o = fn_out[16]; e = 1; end           // R8
    else if (c >= 11 && c <= 16) begin                            // R6
      if (i2c_mode && (c == 14 || c == 15)) begin                 // R7
        od = 1; e = fn_oe[c-11] & ~fn_out[c-1];
      end else begin o = fn_out[c-1]; e = fn_oe[c-11]; end
    end else if (c >= 1 && c <= 10) o = fn_out[c-1];             // R5
    return {o, e, od, ie};                                        // else R3
  endfunction

  function automatic string req_of(input int c);
    if (c == 31) return "R4";
    if (c == 17) return "R8";
    if ((c == 14 || c == 15) && i2c_mode) return "R7";
    if (c >= 11 && c <= 16) return "R6";
    if (c >= 1 && c <= 10) return "R5";
    return "R3";
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: reset defaults read back with upper bits zero
    for (int p = 0; p < NPIN; p++) begin
      cfg_addr = 3'(p); #1;
      check("R2", cfg_rdata, (p < 6) ? 16 - p : 0);
    end

    // R1: upper bits dropped, readback zero-extended
    wr(3, 8'hE5);
    cfg_addr = 3'd3; #1;
    check("R1", cfg_rdata, 8'h05);
    // R4: full-byte analog value becomes code 31
    wr(6, 8'hFF);
    cfg_addr = 3'd6; #1;
    check("R4", cfg_rdata, 8'd31);

    // Sweep every code on every pin, the other pins parked at code 0
    for (int p = 0; p < NPIN; p++) wr(p, 8'h00);
    for (int p = 0; p < NPIN; p++) begin
      for (int c = 0; c < 32; c++) begin
        wr(p, 8'(c) | 8'hA0);
        for (int k = 0; k < 4; k++) begin
          logic [3:0]  e;
          logic [15:0] ein;
          @(negedge clk);
          fn_out   = (k[0]) ? 17'h15A5A : 17'h0A5A5;
          fn_oe    = (k[1]) ? 6'h2D : 6'h12;
          dir      = (k == 2) ? 8'hFF : 8'h55;
          pin_in   = (k[0]) ? 8'hFF : 8'h00;
          i2c_mode = k[1];
          if (k == 3) fn_out = fn_out ^ 17'h06000;
          #1;
          e = model(c, dir[p]);
          check(req_of(c), {pin_out[p], pin_oe[p], pin_od[p], pin_ie[p]}, e);
          ein = '0;
          if (c >= 1 && c <= 16) ein[c-1] = pin_in[p];            // R9 none -> 0
          check((c >= 1 && c <= 16) ? "R5/R6 input" : "R9", fn_in, ein);
        end
      end
      wr(p, 8'h00);
    end

    // R9: two pins share code 11; lowest pin wins
    wr(2, 8'd11); wr(5, 8'd11);
    @(negedge clk); pin_in = 8'b0010_0000; #1;
    check("R9", fn_in[10], 1'b0);
    @(negedge clk); pin_in = 8'b0000_0100; #1;
    check("R9", fn_in[10], 1'b1);
    wr(2, 8'd0); #1;
    check("R9", fn_in[10], 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule